// File: doc/BRIEF.md
# Calibration Request Responder

This block services the read and write requests that a DDR PHY raises while it trains its data capture. It sits between the PHY's request and status outputs and one command phase of a DFI-style memory interface. After reset it opens row 0 of bank 0. It then polls the PHY. Each time the PHY raises a read or write request together with a column index, the block issues the matching column command on the open row. It schedules the read-data or write-data enable at a fixed delay, and pulses an acknowledge bit back to the PHY so that the PHY clears that request.

When the PHY reports that calibration is finished, the block closes every bank with a precharge-all command. It then raises a done flag, which stays high until the next reset. The PHY's own training logic and any comparison of the data are outside this block. The data-enable delays and durations, the index and address widths, and the address bit that selects precharge-all are all parameters.

Top module: `cal_resp_top`

## Requirements
- R1: After reset is released, the block issues one activate command to bank 0 with address 0. On the pins this is cs_n=0, ras_n=0, cas_n=1, we_n=1.
- R2: A read request (phy_req_rd_i=1) produces one read command with cs_n=0, ras_n=1, cas_n=0, we_n=1. The command carries bank 0 and the column address {phy_req_idx_i, 2'b00}, zero-extended to the address width.
- R3: A write request (phy_req_wr_i=1) produces one write command with cs_n=0, ras_n=1, cas_n=0, we_n=0, the same bank and the same column address as R2.
- R4: For a write command visible in cycle T, dfi_wrdata_en_o is high during cycles T+WR_DELAY to T+WR_DELAY+WR_LEN-1 and low in all other cycles. The defaults are 4 and 1.
- R5: For a read command visible in cycle T, dfi_rddata_en_o is high during cycles T+RD_DELAY to T+RD_DELAY+RD_LEN-1 and low in all other cycles. The defaults are 7 and 1.
- R6: phy_req_ack_o pulses for exactly one cycle, in the same cycle as the command it acknowledges. Bit 0 acknowledges a read and bit 1 acknowledges a write.
- R7: When a read request and a write request are pending together, the read is served first and the write follows in a later command slot. Both acknowledge bits are never high in the same cycle.
- R8: After any command, at least max(RD_DELAY+RD_LEN, WR_DELAY+WR_LEN) cycles pass with cs_n=1 before the next command, which is 8 cycles with the defaults. Read and write enables are therefore never high together.
- R9: When phy_cal_done_i is high while the block is polling, the block issues a precharge-all command: cs_n=0, ras_n=1... more precisely ras_n=0, cas_n=1, we_n=0, address 0x0400 (bit PRE_BIT=10 set), bank 0. This command takes priority over any pending request, and no acknowledge is given with it.
- R10: cal_done_o rises in the cycle after the precharge-all command and stays high until reset. While it is high, no further command, acknowledge or data enable is produced, whatever requests arrive.
- R11: While reset is active, cs_n, ras_n, cas_n and we_n are all 1, both data enables are 0, phy_req_ack_o is 0 and cal_done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_req_rd_i | input | 1 | PHY read request pending |
| phy_req_wr_i | input | 1 | PHY write request pending |
| phy_req_idx_i | input | IDX_W | Column index of the pending request |
| phy_cal_done_i | input | 1 | PHY reports calibration finished |
| dfi_cs_n_o | output | 1 | Chip select, active low |
| dfi_ras_n_o | output | 1 | Row strobe, active low |
| dfi_cas_n_o | output | 1 | Column strobe, active low |
| dfi_we_n_o | output | 1 | Write enable, active low |
| dfi_address_o | output | ADDR_W | Row or column address |
| dfi_bank_o | output | BANK_W | Bank address (always 0) |
| dfi_rddata_en_o | output | 1 | Read-data enable |
| dfi_wrdata_en_o | output | 1 | Write-data enable |
| phy_req_ack_o | output | 2 | Acknowledge pulse: bit 0 read, bit 1 write |
| cal_done_o | output | 1 | Sequence finished, held until reset |

## Verification
The assertions check properties that must hold on every cycle. An acknowledge must match the pin pattern of its command, and the two acknowledge bits must never be high together. A counter in the checker enforces the idle gap between commands. The assertions also check that the two enables never overlap, that a precharge-all is followed by done, and that done stays high and silent afterwards. Other behaviours can only be shown by the bench's scenarios. These are the exact cycle offset of each data enable after its command, the column address built from the index, the read-before-write order, precharge winning over a pending request, and the activate that a fresh reset brings back.

// File: rtl/cal_resp_pkg.sv
package cal_resp_pkg;

   // command pin pattern, ordered {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_DESEL = 4'b1111,
      CMD_ACT   = 4'b0011,
      CMD_RD    = 4'b0101,
      CMD_WR    = 4'b0100,
      CMD_PREA  = 4'b0010
   } cmd_e;

   typedef enum logic [1:0] {
      ST_OPEN,
      ST_POLL,
      ST_WAIT,
      ST_DONE
   } state_e;

   localparam int unsigned ACK_RD = 0;
   localparam int unsigned ACK_WR = 1;

endpackage

// File: rtl/cal_resp_den.sv
module cal_resp_den #(
   parameter int unsigned DELAY = 4,
   parameter int unsigned LEN   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic en_o
);
   localparam int unsigned DEPTH = DELAY + LEN;

   // sr[k] is high k cycles after the command cycle
   logic [DEPTH-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[DEPTH-2:0], fire_i};
   end

   generate
      if (LEN == 1) begin : g_single
         assign en_o = sr_q[DELAY];
      end else begin : g_window
         assign en_o = |sr_q[DEPTH-1:DELAY];
      end
   endgenerate

endmodule

// File: rtl/cal_resp_fsm.sv
module cal_resp_fsm
   import cal_resp_pkg::*;
#(
   parameter int unsigned ADDR_W  = 13,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned GAP     = 8,
   parameter int unsigned PRE_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_rd_i,
   input  logic              req_wr_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              cal_done_i,
   output cmd_e              cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        ack_o,
   output logic              rd_fire_o,
   output logic              wr_fire_o,
   output logic              done_o
);
   localparam int unsigned CNT_W = $clog2(GAP + 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP - 1);

   state_e              state_q, state_d;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   cmd_e                cmd_q, cmd_d;
   logic [ADDR_W-1:0]   addr_q, addr_d;
   logic [1:0]          ack_q, ack_d;
   logic                done_q;
   logic [ADDR_W-1:0]   col_addr;

   assign col_addr = ADDR_W'({idx_i, 2'b00});

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      cmd_d     = CMD_DESEL;
      addr_d    = addr_q;
      ack_d     = '0;
      rd_fire_o = 1'b0;
      wr_fire_o = 1'b0;
      unique case (state_q)
         ST_OPEN: begin
            cmd_d   = CMD_ACT;
            addr_d  = '0;
            cnt_d   = GAP_LAST;
            state_d = ST_WAIT;
         end
         ST_POLL: begin
            if (cal_done_i) begin
               cmd_d   = CMD_PREA;
               addr_d  = ADDR_W'(1) << PRE_BIT;
               state_d = ST_DONE;
            end else if (req_rd_i) begin
               cmd_d          = CMD_RD;
               addr_d         = col_addr;
               ack_d[ACK_RD]  = 1'b1;
               rd_fire_o      = 1'b1;
               cnt_d          = GAP_LAST;
               state_d        = ST_WAIT;
            end else if (req_wr_i) begin
               cmd_d          = CMD_WR;
               addr_d         = col_addr;
               ack_d[ACK_WR]  = 1'b1;
               wr_fire_o      = 1'b1;
               cnt_d          = GAP_LAST;
               state_d        = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (cnt_q == '0) state_d = ST_POLL;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_DONE: begin
            state_d = ST_DONE;
         end
         default: state_d = ST_OPEN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_OPEN;
         cnt_q   <= '0;
         cmd_q   <= CMD_DESEL;
         addr_q  <= '0;
         ack_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         cmd_q   <= cmd_d;
         addr_q  <= addr_d;
         ack_q   <= ack_d;
         done_q  <= done_q | (state_q == ST_DONE);
      end
   end

   assign cmd_o  = cmd_q;
   assign addr_o = addr_q;
   assign ack_o  = ack_q;
   assign done_o = done_q;

endmodule

// File: rtl/cal_resp_top.sv
module cal_resp_top
   import cal_resp_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned BANK_W   = 3,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned WR_DELAY = 4,
   parameter int unsigned WR_LEN   = 1,
   parameter int unsigned RD_DELAY = 7,
   parameter int unsigned RD_LEN   = 1,
   parameter int unsigned PRE_BIT  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phy_req_rd_i,
   input  logic              phy_req_wr_i,
   input  logic [IDX_W-1:0]  phy_req_idx_i,
   input  logic              phy_cal_done_i,
   output logic              dfi_cs_n_o,
   output logic              dfi_ras_n_o,
   output logic              dfi_cas_n_o,
   output logic              dfi_we_n_o,
   output logic [ADDR_W-1:0] dfi_address_o,
   output logic [BANK_W-1:0] dfi_bank_o,
   output logic              dfi_rddata_en_o,
   output logic              dfi_wrdata_en_o,
   output logic [1:0]        phy_req_ack_o,
   output logic              cal_done_o
);
   localparam int unsigned RD_SPAN = RD_DELAY + RD_LEN;
   localparam int unsigned WR_SPAN = WR_DELAY + WR_LEN;
   localparam int unsigned GAP_CYC = (RD_SPAN > WR_SPAN) ? RD_SPAN : WR_SPAN;

   generate
      if (IDX_W + 2 > ADDR_W) begin : g_bad_idx
         $error("IDX_W + 2 must fit in ADDR_W");
      end
      if (PRE_BIT >= ADDR_W) begin : g_bad_pre
         $error("PRE_BIT must lie inside the address");
      end
      if (RD_DELAY < 1 || WR_DELAY < 1 || RD_LEN < 1 || WR_LEN < 1) begin : g_bad_den
         $error("data-enable delays and lengths must be at least 1");
      end
   endgenerate

   cmd_e cmd;
   logic rd_fire, wr_fire;

   cal_resp_fsm #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .GAP    (GAP_CYC),
      .PRE_BIT(PRE_BIT)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_rd_i  (phy_req_rd_i),
      .req_wr_i  (phy_req_wr_i),
      .idx_i     (phy_req_idx_i),
      .cal_done_i(phy_cal_done_i),
      .cmd_o     (cmd),
      .addr_o    (dfi_address_o),
      .ack_o     (phy_req_ack_o),
      .rd_fire_o (rd_fire),
      .wr_fire_o (wr_fire),
      .done_o    (cal_done_o)
   );

   cal_resp_den #(.DELAY(RD_DELAY), .LEN(RD_LEN)) rd_den_i (
      .clk(clk), .rst_n(rst_n), .fire_i(rd_fire), .en_o(dfi_rddata_en_o)
   );

   cal_resp_den #(.DELAY(WR_DELAY), .LEN(WR_LEN)) wr_den_i (
      .clk(clk), .rst_n(rst_n), .fire_i(wr_fire), .en_o(dfi_wrdata_en_o)
   );

   assign {dfi_cs_n_o, dfi_ras_n_o, dfi_cas_n_o, dfi_we_n_o} = cmd;
   assign dfi_bank_o = '0;

endmodule

// File: rtl/cal_resp_chk.sv
module cal_resp_chk #(
   parameter int unsigned GAP = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       dfi_cs_n_o,
   input logic       dfi_ras_n_o,
   input logic       dfi_cas_n_o,
   input logic       dfi_we_n_o,
   input logic       dfi_rddata_en_o,
   input logic       dfi_wrdata_en_o,
   input logic [1:0] phy_req_ack_o,
   input logic       cal_done_o
);
   localparam int unsigned CW = $clog2(GAP + 2);

   logic [CW-1:0] since_q;
   logic          seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (!dfi_cs_n_o) begin
         since_q <= '0;
         seen_q  <= 1'b1;
      end else if (since_q < CW'(GAP)) begin
         since_q <= since_q + 1'b1;
      end
   end

   logic is_prea;
   assign is_prea = !dfi_cs_n_o && !dfi_ras_n_o && dfi_cas_n_o && !dfi_we_n_o;

   AST_RD_ACK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_ack_o[0] |-> (!dfi_cs_n_o && dfi_ras_n_o && !dfi_cas_n_o && dfi_we_n_o)); // R2
   AST_WR_ACK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_ack_o[1] |-> (!dfi_cs_n_o && dfi_ras_n_o && !dfi_cas_n_o && !dfi_we_n_o)); // R3
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req_ack_o != 2'b00) |=> (phy_req_ack_o == 2'b00)); // R6
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phy_req_ack_o)); // R7
   AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!dfi_cs_n_o && seen_q) |-> (since_q >= CW'(GAP))); // R8
   AST_EN_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      !(dfi_rddata_en_o && dfi_wrdata_en_o)); // R8
   AST_PREA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      is_prea |=> cal_done_o); // R9
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done_o |=> cal_done_o); // R10
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done_o |-> (dfi_cs_n_o && phy_req_ack_o == 2'b00 && !dfi_rddata_en_o && !dfi_wrdata_en_o)); // R10

endmodule

bind cal_resp_top cal_resp_chk #(.GAP(GAP_CYC)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .dfi_cs_n_o     (dfi_cs_n_o),
   .dfi_ras_n_o    (dfi_ras_n_o),
   .dfi_cas_n_o    (dfi_cas_n_o),
   .dfi_we_n_o     (dfi_we_n_o),
   .dfi_rddata_en_o(dfi_rddata_en_o),
   .dfi_wrdata_en_o(dfi_wrdata_en_o),
   .phy_req_ack_o  (phy_req_ack_o),
   .cal_done_o     (cal_done_o)
);

// File: tb/cal_resp_tb.sv
module cal_resp_top_tb_top;
   localparam int ADDR_W = 13;
   localparam int IDX_W  = 8;
   localparam int WRD    = 4;
   localparam int RDD    = 7;
   localparam int GAP    = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_rd = 1'b0, req_wr = 1'b0, cal_done_in = 1'b0;
   logic [IDX_W-1:0]  idx = '0;
   logic              cs_n, ras_n, cas_n, we_n, rden, wren, done;
   logic [ADDR_W-1:0] addr;
   logic [2:0]        bank;
   logic [1:0]        ack;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cal_resp_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .phy_req_rd_i(req_rd), .phy_req_wr_i(req_wr),
      .phy_req_idx_i(idx), .phy_cal_done_i(cal_done_in),
      .dfi_cs_n_o(cs_n), .dfi_ras_n_o(ras_n), .dfi_cas_n_o(cas_n), .dfi_we_n_o(we_n),
      .dfi_address_o(addr), .dfi_bank_o(bank),
      .dfi_rddata_en_o(rden), .dfi_wrdata_en_o(wren),
      .phy_req_ack_o(ack), .cal_done_o(done)
   );

   // {rd, wr, idx}
   localparam logic [9:0] VEC [6] = '{
      {1'b1, 1'b0, 8'd0},
      {1'b0, 1'b1, 8'd1},
      {1'b1, 1'b0, 8'd255},
      {1'b0, 1'b1, 8'd170},
      {1'b1, 1'b1, 8'd37},
      {1'b0, 1'b1, 8'd85}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cmd(output bit found);
      found = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!cs_n) begin
            found = 1'b1;
            break;
         end
      end
   endtask

   // kind: 0 act, 1 read, 2 write; checks idle window and enables after command
   task automatic idle_window(input int kind);
      for (int k = 1; k <= GAP; k++) begin
         @(negedge clk);
         chk(cs_n == 1'b1, "R8 idle gap", cs_n, 1);
         chk(rden == (kind == 1 && k == RDD), "R5 rddata_en timing", rden, (kind == 1 && k == RDD));
         chk(wren == (kind == 2 && k == WRD), "R4 wrdata_en timing", wren, (kind == 2 && k == WRD));
         chk(ack == 2'b00, "R6 ack single cycle", ack, 0);
      end
   endtask

   task automatic serve(input int kind, input logic [IDX_W-1:0] ix);
      bit found;
      logic [3:0] pins;
      logic [3:0] exp_pins;
      wait_cmd(found);
      chk(found, (kind == 1) ? "R2 read command issued" : "R3 write command issued", found, 1);
      pins = {cs_n, ras_n, cas_n, we_n};
      exp_pins = (kind == 1) ? 4'b0101 : 4'b0100;
      chk(pins == exp_pins, (kind == 1) ? "R2 read pins" : "R3 write pins", pins, exp_pins);
      chk(addr == ADDR_W'({ix, 2'b00}), "R2 column address", addr, {ix, 2'b00});
      chk(bank == 3'd0, "R3 bank zero", bank, 0);
      chk(ack == ((kind == 1) ? 2'b01 : 2'b10), "R6 ack bit", ack, (kind == 1) ? 1 : 2);
      if (kind == 1) req_rd = 1'b0; else req_wr = 1'b0;
      idle_window(kind);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R11 reset pins", {cs_n, ras_n, cas_n, we_n}, 4'hf);
      chk(!rden && !wren, "R11 reset enables", {rden, wren}, 0);
      chk(ack == 2'b00 && !done, "R11 reset ack/done", {ack, done}, 0);
      rst_n = 1'b1;
   endtask

   task automatic expect_act();
      bit found;
      wait_cmd(found);
      chk(found, "R1 activate issued", found, 1);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0011, "R1 activate pins", {cs_n, ras_n, cas_n, we_n}, 4'h3);
      chk(addr == '0 && bank == '0, "R1 row/bank zero", {bank, addr}, 0);
      idle_window(0);
   endtask

   initial begin
      #(4 * 20000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit found;
      do_reset();
      expect_act();

      foreach (VEC[v]) begin
         req_rd = VEC[v][9];
         req_wr = VEC[v][8];
         idx    = VEC[v][7:0];
         if (VEC[v][9]) serve(1, VEC[v][7:0]);  // R7: read comes first
         if (VEC[v][8]) serve(2, VEC[v][7:0]);
      end

      // R9: done wins over a pending write
      req_wr = 1'b1; idx = 8'd5; cal_done_in = 1'b1;
      wait_cmd(found);
      chk(found, "R9 precharge issued", found, 1);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0010, "R9 precharge pins", {cs_n, ras_n, cas_n, we_n}, 4'h2);
      chk(addr == 13'h0400 && bank == 3'd0, "R9 precharge address", addr, 13'h400);
      chk(ack == 2'b00, "R9 no ack with precharge", ack, 0);
      chk(!done, "R10 done not yet", done, 0);
      @(negedge clk);
      chk(done, "R10 done after precharge", done, 1);
      req_rd = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(done && cs_n && ack == 2'b00 && !rden && !wren, "R10 quiet and held",
             {done, cs_n, ack, rden, wren}, 6'b110000);
      end
      req_rd = 1'b0; req_wr = 1'b0; cal_done_in = 1'b0;

      // reset clears done and reopens the row
      do_reset();
      chk(!done, "R10 cleared by reset", done, 0);
      expect_act();
      req_wr = 1'b1; idx = 8'd3;
      serve(2, 8'd3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule